// File: doc/BRIEF.md
# Self-Addressing Byte-Wide ROM Slave

This block sits on the memory side of an 8-bit bus and serves a ROM of 16K words of 16 bits. The bus carries no address for sequential code. Instead the block keeps two pointers of its own. The first is a program pointer, which steps forward by one byte every time the processor asks for the next instruction byte. The second is a data pointer, which holds still until the processor loads it again.

Each 16-bit word is moved as two byte transfers. Byte addresses are 15 bits wide. Address bit 0 chooses the low byte (0) or the high byte (1), so the low byte of a word is returned first. Loading a pointer takes two bus cycles, and the pointer changes only when the second byte arrives.

A test mode lets an outside tester dump the ROM. The tester clears the program pointer with an active-low memory reset, then pulses an active-low strobe once per byte. The ROM image is a fixed computed pattern, so no stored table is needed.

Top module: `nbus_rom_slave`

## Requirements
- R1: After `rst_n` is released, `rd_valid` is 0 and both pointers are 0. The first fetch therefore returns the byte at address 0.
- R2: When `cmd_valid` is high, `test_mode` is low and `cmd`=2'b00 (fetch), the block returns the byte at the program pointer. The pointer then advances by one.
- R3: The byte at address A belongs to word W = A[14:1]. The high byte is (W[13:6] XOR 8'h5A) and the low byte is (W[7:0] + 8'h3C) mod 256. A[0]=1 selects the high byte and A[0]=0 selects the low byte.
- R4: `cmd`=2'b01 loads the program pointer over two commands: the first carries address bits [7:0] and the second carries bits [14:8] in `cmd_data[6:0]`, with `cmd_data[7]` ignored. The program pointer does not change until the second byte is taken.
- R5: `cmd`=2'b10 loads the data pointer over two commands, using the same byte order and update rule as R4.
- R6: `cmd`=2'b11 returns the byte at the data pointer and leaves the data pointer unchanged.
- R7: A data read placed between two fetches does not disturb the program pointer. The next fetch returns the next sequential program byte.
- R8: The program pointer wraps from 15'h7FFF to 0.
- R9: Each byte read shows on `rd_data` in the cycle after its command or strobe. `rd_valid` is high for exactly that one cycle.
- R10: While `test_rst_n` is low, the program pointer is forced to 0. Any command or strobe in that cycle is ignored and produces no `rd_valid`.
- R11: With `test_mode` high, each high-to-low edge of `test_stb_n` returns the byte at the program pointer and advances the pointer once. A strobe held low gives no further bytes, and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 2 | 00 fetch, 01 program pointer byte, 10 data pointer byte, 11 data read |
| cmd_data | input | 8 | Address byte for the load commands |
| test_mode | input | 1 | Tester owns the block |
| test_rst_n | input | 1 | Active-low memory reset for the program pointer |
| test_stb_n | input | 1 | Active-low dump strobe |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | One-cycle mark for rd_data |

## Verification
The directed sequences each target one behaviour:
- A run of plain fetches separates a pointer that counts from one that does not.
- A fetch issued between the two halves of a pointer load shows whether the pointer updates early.
- Fetches placed on both sides of a data read, and repeated data reads, separate the two pointers from each other.
- Loading the top address and fetching twice exposes a faulty wrap.
- Holding the strobe low separates edge detection from level detection.
- A command issued under the memory reset checks that the reset takes priority.

A long seeded random mix of all four commands then runs against a bench model of both pointers. This mix catches wrong byte selection and pointer corruption that only appear in less common orderings.

// File: rtl/nbus_rom_slave.sv
module nbus_rom_slave #(
  parameter int WORD_AW = 14,
  parameter int BYTE_AW = WORD_AW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic [7:0] cmd_data,
  input  logic       test_mode,
  input  logic       test_rst_n,
  input  logic       test_stb_n,
  output logic [7:0] rd_data,
  output logic       rd_valid
);
  localparam int HI_W = BYTE_AW - 8;
  localparam logic [1:0] C_FETCH = 2'b00, C_LDPC = 2'b01, C_LDDA = 2'b10, C_RDDA = 2'b11;

  function automatic logic [7:0] rom_byte(input logic [BYTE_AW-1:0] a);
    logic [WORD_AW-1:0] w;
    w = a[BYTE_AW-1:1];
    return a[0] ? (w[WORD_AW-1 -: 8] ^ 8'h5A) : (w[7:0] + 8'h3C);
  endfunction

  logic [BYTE_AW-1:0] pc, da;
  logic [7:0] pc_lo, da_lo;
  logic       pc_ph, da_ph, stb_q;

  wire acc      = cmd_valid && !test_mode && test_rst_n;
  wire stb_edge = test_mode && test_rst_n && stb_q && !test_stb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; da <= '0; pc_lo <= '0; da_lo <= '0;
      pc_ph <= 1'b0; da_ph <= 1'b0; stb_q <= 1'b1;
      rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      stb_q    <= test_stb_n;
      rd_valid <= 1'b0;
      if (!test_rst_n) begin
        pc    <= '0;
        pc_ph <= 1'b0;
      end else if (stb_edge) begin
        rd_data  <= rom_byte(pc);
        rd_valid <= 1'b1;
        pc       <= pc + 1'b1;
      end else if (acc) begin
        case (cmd)
          C_FETCH: begin
            rd_data  <= rom_byte(pc);
            rd_valid <= 1'b1;
            pc       <= pc + 1'b1;
          end
          C_LDPC: begin
            if (!pc_ph) pc_lo <= cmd_data;
            else        pc    <= {cmd_data[HI_W-1:0], pc_lo};
            pc_ph <= !pc_ph;
          end
          C_LDDA: begin
            if (!da_ph) da_lo <= cmd_data;
            else        da    <= {cmd_data[HI_W-1:0], da_lo};
            da_ph <= !da_ph;
          end
          default: begin
            rd_data  <= rom_byte(da);
            rd_valid <= 1'b1;
          end
        endcase
      end
    end
  end

  // R2
  fetch_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd == C_FETCH) |=> (pc == $past(pc) + 1'b1) && rd_valid);
  // R6
  data_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd == C_RDDA) |=> $stable(da) && $stable(pc));
  // R4
  half_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd == C_LDPC && !pc_ph) |=> $stable(pc));
  // R10
  mem_reset_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_rst_n |=> (pc == '0) && !rd_valid);
  // R11
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !test_stb_n && !stb_q) |=> !rd_valid);
endmodule

// File: tb/sim_nbus_rom_slave.sv
module sim_nbus_rom_slave;
  logic clk = 0, rst_n = 0, cmd_valid = 0, test_mode = 0, test_rst_n = 1, test_stb_n = 1;
  logic [1:0] cmd = 0;
  logic [7:0] cmd_data = 0;
  logic [7:0] rd_data;
  logic rd_valid;
  int total = 0, fails = 0, cycles = 0;
  logic [14:0] bpc = 0, bda = 0;
  logic [7:0] bpc_lo = 0, bda_lo = 0;
  bit bpc_ph = 0, bda_ph = 0;

  nbus_rom_slave u0 (.clk, .rst_n, .cmd_valid, .cmd, .cmd_data, .test_mode,
                     .test_rst_n, .test_stb_n, .rd_data, .rd_valid);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; fails++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic logic [7:0] expect_byte(input logic [14:0] a);
    logic [15:0] word;
    word[15:8] = {a[14:7]} ^ 8'h5A;
    word[7:0]  = {1'b0, a[7:1]} + 8'h3C;
    word[7:0]  = 8'((int'(a[8:1]) + 60) % 256);
    return a[0] ? word[15:8] : word[7:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] c, input logic [7:0] d, input string req);
    logic [7:0] e; bit v;
    cmd_valid = 1; cmd = c; cmd_data = d;
    @(negedge clk);
    v = 0; e = 0;
    case (c)
      2'b00: begin v = 1; e = expect_byte(bpc); bpc = bpc + 1; end
      2'b01: begin if (!bpc_ph) bpc_lo = d; else bpc = {d[6:0], bpc_lo}; bpc_ph = !bpc_ph; end
      2'b10: begin if (!bda_ph) bda_lo = d; else bda = {d[6:0], bda_lo}; bda_ph = !bda_ph; end
      default: begin v = 1; e = expect_byte(bda); end
    endcase
    check(req, rd_valid, v);
    if (v) check(req, rd_data, e);
  endtask

  task automatic idle(input string req);
    cmd_valid = 0;
    @(negedge clk);
    check(req, rd_valid, 0);
  endtask

  task automatic strobe(input logic [14:0] exp_a);
    test_stb_n = 0;
    @(negedge clk);
    check("R11", rd_valid, 1);
    check("R11", rd_data, expect_byte(exp_a));
    @(negedge clk);
    check("R11 held", rd_valid, 0);
    test_stb_n = 1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", rd_valid, 0);
    op(2'b11, 0, "R1 data ptr zero");
    op(2'b00, 0, "R1 R3 first fetch");
    idle("R9");
    repeat (5) op(2'b00, 0, "R2 R3");
    idle("R9");
    op(2'b01, 8'h34, "R4 low");
    op(2'b00, 0, "R4 not yet");
    op(2'b01, 8'h92, "R4 high bit7 ignored");
    op(2'b00, 0, "R4 loaded");
    check("R4", bpc, 15'h1235);
    op(2'b10, 8'h07, "R5");
    op(2'b10, 8'h21, "R5");
    op(2'b11, 0, "R6");
    op(2'b11, 0, "R6 stable");
    op(2'b00, 0, "R7 before");
    op(2'b11, 0, "R7 read");
    op(2'b00, 0, "R7 after");
    op(2'b01, 8'hFF, "R8");
    op(2'b01, 8'h7F, "R8");
    op(2'b00, 0, "R8 top");
    op(2'b00, 0, "R8 wrapped");
    check("R8", bpc, 1);
    // R10: fetch under memory reset is ignored
    test_rst_n = 0; cmd_valid = 1; cmd = 2'b00;
    @(negedge clk);
    check("R10", rd_valid, 0);
    test_rst_n = 1; bpc = 0;
    op(2'b00, 0, "R10 pointer zero");
    // R11 dump
    cmd_valid = 0; test_mode = 1;
    test_rst_n = 0; @(negedge clk); test_rst_n = 1; bpc = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) strobe(15'(i));
    cmd_valid = 1; cmd = 2'b00;
    @(negedge clk);
    check("R11 cmd ignored", rd_valid, 0);
    cmd_valid = 0; test_mode = 0; bpc = 4;
    @(negedge clk);
    op(2'b00, 0, "R11 advanced four");
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom_range(0, 3);
      op(r[1:0], 8'($urandom), "R2 R5 R6 R7 random");
    end
    idle("R9");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule